// File: doc/BRIEF.md
# UART Transmit Handoff with Holding-Empty Status

This block sits between a processor write port and the serial output of one UART channel. Bytes written by the processor wait in a holding stage. When the holding stage has a byte and the shifter can take it, the byte moves into a shift register, which sends it as an 8N1 frame. The shifter moves one bit on each single-cycle baud tick. The holding stage works in one of two ways, selected by `fifo_mode`. With `fifo_mode` low it holds a single byte. With `fifo_mode` high it is a 16-entry first-in first-out queue.

The block drives three status outputs. `hold_empty` reports that the holding stage can take more data. `tx_empty` reports that the holding stage and the shifter have both drained. `thre_irq` is the holding-empty interrupt request, gated by an enable input. A baud-rate generator upstream supplies `baud_tick`. The processor polls the status outputs or waits on the interrupt before it writes the next bytes.

Top module: `uart_tx_handoff`

## Requirements
- R1: After reset, `tx_line` is 1, `hold_empty` is 1, `tx_empty` is 1, and the holding stage holds no byte.
- R2: A frame is sent in this order: one start bit of 0, then the 8 data bits least significant bit first, then one stop bit of 1. While no frame is being sent, `tx_line` is 1.
- R3: Each bit of a frame begins on the clock edge that samples `baud_tick` high and holds for one tick period. `tx_line` changes only on edges where `baud_tick` is high.
- R4: A byte moves from the holding stage into the shifter on a tick, in either of two cases: the shifter is idle, or the tick ends a stop bit. In the second case the next start bit follows the stop bit with no idle gap.
- R5: With `fifo_mode` low, the holding stage keeps one byte. `hold_empty` goes to 1 when that byte moves into the shifter, and goes to 0 on the edge after a write.
- R6: With `fifo_mode` high, `hold_empty` is 1 exactly when the 16-entry queue is empty. It goes to 0 on the edge after any write.
- R7: `tx_empty` is 1 only when the holding stage is empty and no frame is being sent. It goes to 0 once the holding stage holds a byte.
- R8: `thre_irq` is 1 exactly when `hold_empty` and `thre_ie` are both 1.
- R9: With `fifo_mode` high, a write to a full queue is dropped, and the queued bytes and their order stay unchanged.
- R10: A write in the same cycle as a transfer into the shifter is kept. This holds even when the holding stage is full at that moment.
- R11: With `fifo_mode` low, a write while the single holding byte is still waiting replaces that byte. The transmitted stream shows the replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding byte |
| wr_en | input | 1 | Processor write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | Single-cycle bit-rate strobe |
| thre_ie | input | 1 | Holding-empty interrupt enable |
| tx_line | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding stage is empty |
| tx_empty | output | 1 | Holding stage and shifter are both idle |
| thre_irq | output | 1 | Holding-empty interrupt request |

## Verification
The assertions assume that `fifo_mode` stays constant between resets, because the holding capacity and the overwrite rule both depend on it. The stimulus changes the mode only while reset is held. It then runs each mode in separate phases. These phases include write bursts faster than the bit rate, to fill the queue and repeat the overwrite, and random sparse ticks, which make writes collide with transfers. The assertions also assume that `baud_tick` and `wr_en` are zero or one on every edge. The bench drives them only from its own stimulus loop.

// File: rtl/uart_tx_handoff.sv
module uart_tx_handoff #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          baud_tick,
  input  logic          thre_ie,
  output logic          tx_line,
  output logic          hold_empty,
  output logic          tx_empty,
  output logic          thre_irq
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int BW   = $clog2(DW + 2);
  localparam int LAST = DW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          busy;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] shreg;

  wire [CW-1:0]   cap         = fifo_mode ? CW'(DEPTH) : CW'(1);
  wire            full        = (count >= cap);
  wire            stage_empty = (count == '0);
  wire            frame_end   = busy && (bit_idx == BW'(LAST));
  wire            pop         = baud_tick && !stage_empty && (!busy || frame_end);
  wire            push        = wr_en && (!full || pop);
  wire            overwrite   = wr_en && full && !pop && !fifo_mode;
  wire [DW+1:0]   frame       = {1'b1, shreg, 1'b0};

  always_ff @(posedge clk) begin
    if (push)
      mem[wr_ptr] <= wr_data;
    else if (overwrite)
      mem[rd_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (pop) begin
      busy    <= 1'b1;
      bit_idx <= '0;
      shreg   <= mem[rd_ptr];
    end else if (baud_tick && busy) begin
      if (frame_end) busy <= 1'b0;
      else           bit_idx <= bit_idx + 1'b1;
    end
  end

  assign tx_line    = busy ? frame[bit_idx] : 1'b1;
  assign hold_empty = stage_empty;
  assign tx_empty   = stage_empty && !busy;
  assign thre_irq   = stage_empty && thre_ie;
endmodule

// File: rtl/uart_tx_handoff_sva.sv
module uart_tx_handoff_sva #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic          wr_en,
  input logic          baud_tick,
  input logic          thre_ie,
  input logic          tx_line,
  input logic          hold_empty,
  input logic          tx_empty,
  input logic          thre_irq,
  input logic [CW-1:0] count
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_line);

  p_line_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx_line));

  p_hold_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !wr_en) |=> $stable(hold_empty));

  p_single_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> (count <= CW'(1)));

  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);

  p_tx_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_empty && thre_ie) |-> thre_irq);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> (thre_ie && hold_empty));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

bind uart_tx_handoff uart_tx_handoff_sva #(.DEPTH(DEPTH), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .wr_en(wr_en),
  .baud_tick(baud_tick), .thre_ie(thre_ie), .tx_line(tx_line),
  .hold_empty(hold_empty), .tx_empty(tx_empty), .thre_irq(thre_irq),
  .count(count)
);

// File: tb/uart_tx_handoff_tb_top.sv
`timescale 1ns/1ps
module uart_tx_handoff_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic baud_tick = 1'b0;
  logic thre_ie = 1'b0;
  logic tx_line, hold_empty, tx_empty, thre_irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  byte unsigned q[$];
  bit   m_busy;
  int   m_idx;
  logic [7:0] m_sh;

  always #4 clk = ~clk;

  uart_tx_handoff dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .wr_en(wr_en),
    .wr_data(wr_data), .baud_tick(baud_tick), .thre_ie(thre_ie),
    .tx_line(tx_line), .hold_empty(hold_empty), .tx_empty(tx_empty),
    .thre_irq(thre_irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic logic m_line();
    if (!m_busy) return 1'b1;
    if (m_idx == 0) return 1'b0;
    if (m_idx == 9) return 1'b1;
    return m_sh[m_idx-1];
  endfunction

  task automatic compare(input string line_tag);
    chk(line_tag, tx_line, m_line());
    chk(fifo_mode ? "R6 hold_empty" : "R5 hold_empty", hold_empty, q.size() == 0);
    chk("R7 tx_empty", tx_empty, (q.size() == 0) && !m_busy);
    chk("R8 thre_irq", thre_irq, (q.size() == 0) && thre_ie);
  endtask

  task automatic model_step();
    bit popped = 1'b0;
    int cap = fifo_mode ? 16 : 1;
    if (baud_tick && q.size() > 0 && (!m_busy || m_idx == 9)) begin
      m_sh = q.pop_front();
      m_busy = 1'b1;
      m_idx = 0;
      popped = 1'b1;
    end else if (baud_tick && m_busy) begin
      if (m_idx == 9) m_busy = 1'b0;
      else m_idx++;
    end
    if (wr_en) begin
      if (q.size() < cap) q.push_back(wr_data);
      else if (!fifo_mode) q[0] = wr_data;
    end
    if (popped) begin end
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    baud_tick = 1'b0;
    fifo_mode = mode;
    q.delete();
    m_busy = 1'b0;
    m_idx = 0;
    m_sh = '0;
    repeat (3) @(negedge clk);
    chk("R1 tx_line", tx_line, 1'b1);
    chk("R1 hold_empty", hold_empty, 1'b1);
    chk("R1 tx_empty", tx_empty, 1'b1);
    rst_n = 1'b1;
  endtask

  // one cycle: compare at negedge, drive inputs, advance model
  task automatic cycle(input string tag, input bit w, input byte unsigned d, input bit t);
    @(negedge clk);
    compare(tag);
    wr_en = w;
    wr_data = d;
    baud_tick = t;
    model_step();
  endtask

  task automatic run_random(input string tag, input int n, input int wpct, input int tdiv);
    for (int i = 0; i < n; i++) begin
      bit w = ($urandom % 100) < wpct;
      bit t = ($urandom % tdiv) == 0;
      if (($urandom % 50) == 0) thre_ie = ~thre_ie;
      cycle(tag, w, byte'($urandom), t);
    end
  endtask

  task automatic drain(input string tag, input int n, input int tdiv);
    for (int i = 0; i < n; i++) cycle(tag, 1'b0, 8'h00, (i % tdiv) == 0);
  endtask

  initial begin
    thre_ie = 1'b1;
    // non-FIFO mode: frame order, tick timing, overwrite of waiting byte
    do_reset(1'b0);
    cycle("R2 frame", 1'b1, 8'hA5, 1'b0);
    drain("R2 R3 frame bits", 60, 4);
    cycle("R11 first", 1'b1, 8'h3C, 1'b0);
    cycle("R11 replace", 1'b1, 8'hC3, 1'b0);
    drain("R11 replaced stream", 60, 4);
    run_random("R4 R10 nonfifo random", 4000, 10, 3);
    drain("R3 drain", 200, 2);

    // FIFO mode: fill beyond capacity, back-to-back frames
    do_reset(1'b1);
    for (int i = 0; i < 20; i++) cycle("R9 burst", 1'b1, byte'(8'h10 + i), 1'b0);
    drain("R4 R9 back-to-back", 800, 3);
    for (int i = 0; i < 16; i++) cycle("R10 fill", 1'b1, byte'(8'h80 + i), 1'b0);
    for (int i = 0; i < 40; i++) cycle("R10 full write with transfer", 1'b1, byte'(8'hE0 + i), 1'b1);
    drain("R6 drain", 1200, 2);
    run_random("R6 R10 fifo random", 6000, 30, 4);
    drain("R7 final drain", 1500, 2);

    // mode back to single byte after reset
    do_reset(1'b0);
    thre_ie = 1'b0;
    run_random("R5 R8 nonfifo random", 2000, 20, 5);
    drain("R5 drain", 200, 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule